// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the slave-side command engine of a page-organised serial memory. It accepts SPI traffic in clock mode 0 or mode 3. Input bits are taken on each rising SCK edge and output bits change after each falling edge, always most significant bit first. The first byte after select is an opcode. The engine can read a stream of bytes, load a page buffer and commit it with a self-timed write, read or write a small status register, set or clear the write-enable flag, and return a fixed signature byte.

The serial pins are sampled on a fast system clock, so SCK, CS_n and SI must already be synchronous to `clk`. Storage is a byte array of 2^ADDR_W entries, written one page at a time. A page holds 2^COL_W bytes. A commit copies only the loaded bytes of the page buffer into the array during a busy window of WR_CYCLES clocks. An external protection unit decides whether a page may be written. It sees the stored protection bits on `blk_cfg` and the target page on `tgt_page`, and it answers on `wr_allow`.

Top module: `smc_engine`

## Requirements
- R1: Opcodes are 0x01 status write, 0x02 page write, 0x03 read, 0x04 write disable, 0x05 status read, 0x06 write enable and 0xAB signature. Bits are taken MSB first on SCK rise, and `so` changes after SCK fall. `so_oe` is high only in an output phase with CS_n low. Modes 0 and 3 both work.
- R2: A status read returns {bit7 protect-enable, bits 6:4 zero, bits 3:2 block bits, bit1 write-enable, bit0 busy}, MSB first. It repeats the byte, refreshed, for as long as clocks continue.
- R3: Write enable sets the write-enable flag when its opcode byte completes. Write disable clears it.
- R4: A status write changes the status register only when write-enable is set, exactly one data byte was sent and CS_n rises on the byte boundary. It stores data bits 7, 3 and 2, ignores the other bits and clears write-enable. `blk_cfg` shows {bit7, bit3, bit2}.
- R5: A read takes a 24-bit address, of which the low ADDR_W bits are used. It then streams bytes with the address incrementing and rolls over from the top address to 0.
- R6: During a page write only the low COL_W address bits advance, so the column wraps inside the page and later bytes overwrite earlier ones. Bytes of the page that were not loaded keep their old contents.
- R7: A page write commits only if CS_n rises on a byte boundary after at least one data byte, with write-enable set and `wr_allow` high. A rise of CS_n in the middle of a byte cancels the write.
- R8: After a commit the busy window lasts WR_CYCLES clocks. Status bits 1:0 read 1 during it, and write-enable reads 0 after it ends.
- R9: While busy, every opcode except status read is ignored: no output is driven and no state changes.
- R10: The signature opcode is followed by three dummy bytes. The engine then outputs 0x11 repeatedly while clocks continue.
- R11: After an unknown opcode the rest of the selection is ignored and `so_oe` stays low until the next falling edge of CS_n.
- R12: `tgt_page` shows the page number of the address of the page write in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial pins are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| wr_allow | input | 1 | External permit for committing the targeted page |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (high-impedance when low) |
| blk_cfg | output | 3 | Stored {protect-enable, block bit 1, block bit 0} |
| tgt_page | output | ADDR_W-COL_W | Page addressed by the current page write |

## Verification
Page writes are tried with a short run in the middle of a page, a run of 258 bytes that wraps and overwrites, single bytes at the top and bottom of the array, a cut-off byte and a denied permit. Reading each result back tells column wrap apart from page carry, and tells committed bytes apart from untouched ones. Status reads in both clock modes, before, during and after a busy window, separate the effects of enable, disable and the status write. Traffic sent during busy and after an unknown opcode must leave the output enable quiet and the array unchanged.

// File: rtl/smc_pkg.sv
package smc_pkg;
   localparam logic [7:0] OP_SR_WR  = 8'h01;
   localparam logic [7:0] OP_PG_WR  = 8'h02;
   localparam logic [7:0] OP_RD     = 8'h03;
   localparam logic [7:0] OP_WDIS   = 8'h04;
   localparam logic [7:0] OP_SR_RD  = 8'h05;
   localparam logic [7:0] OP_WEN    = 8'h06;
   localparam logic [7:0] OP_SIG    = 8'hAB;

   typedef enum logic [3:0] {
      S_OPC, S_ADDR, S_WDATA, S_RD, S_SROUT, S_SRIN, S_SRDONE, S_DUMMY, S_ID, S_SKIP
   } smc_st_e;
endpackage

// File: rtl/smc_rx.sv
module smc_rx (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       rise,
   input  logic       si,
   output logic       byte_done,
   output logic [7:0] byte_val,
   output logic [2:0] bit_idx
);
   logic [6:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         bit_idx <= '0;
      end else if (clr) begin
         bit_idx <= '0;
      end else if (rise) begin
         sh      <= {sh[5:0], si};
         bit_idx <= bit_idx + 3'd1;
      end
   end

   assign byte_done = rise && (bit_idx == 3'd7);
   assign byte_val  = {sh, si};

   // R1: a byte boundary returns the bit position to zero
   a_r1_byte_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && !clr) |=> (bit_idx == 3'd0));
endmodule

// File: rtl/smc_pgbuf.sv
module smc_pgbuf #(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ld,
   input  logic [COL_W-1:0] ld_col,
   input  logic [7:0]       ld_data,
   input  logic [COL_W-1:0] rd_col,
   output logic [7:0]       rd_data,
   output logic             rd_mask,
   output logic             any
);
   localparam int PAGE_BYTES = 1 << COL_W;

   logic [7:0]            bytes [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] mask;

   always_ff @(posedge clk) begin
      if (ld) bytes[ld_col] <= ld_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mask <= '0;
      else if (clr) mask <= '0;
      else if (ld)  mask[ld_col] <= 1'b1;
   end

   assign rd_data = bytes[rd_col];
   assign rd_mask = mask[rd_col];
   assign any     = |mask;

   // R6: loaded columns are only ever added until the next clear
   a_r6_mask_grows: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ($countones(mask) >= $past($countones(mask))));
endmodule

// File: rtl/smc_wtimer.sv
module smc_wtimer #(
   parameter int WR_CYCLES = 300,
   parameter int COL_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic             done,
   output logic             copy,
   output logic [COL_W-1:0] idx
);
   localparam int PAGE_BYTES = 1 << COL_W;
   localparam int CNT_W      = $clog2(WR_CYCLES + 1);

   if (WR_CYCLES < PAGE_BYTES) begin : g_chk_len
      $error("WR_CYCLES must cover one clock per page byte");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         cnt  <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
         end else if (busy) begin
            if (cnt == CNT_W'(WR_CYCLES - 1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign copy = busy && (cnt < CNT_W'(PAGE_BYTES));
   assign idx  = cnt[COL_W-1:0];

   // R8: a commit opens the busy window and none is accepted inside it
   a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);
endmodule

// File: rtl/smc_mem.sv
module smc_mem #(
   parameter int ADDR_W     = 11,
   parameter bit ERASE_INIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [7:0]        rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0] mem [DEPTH];

   if (ERASE_INIT) begin : g_erased
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
         end else if (we) begin
            mem[waddr] <= wdata;
         end
      end
   end else begin : g_plain
      always_ff @(posedge clk) begin
         if (we) mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/smc_engine.sv
module smc_engine
   import smc_pkg::*;
#(
   parameter int         ADDR_W     = 11,
   parameter int         COL_W      = 8,
   parameter int         WR_CYCLES  = 300,
   parameter logic [7:0] SIG        = 8'h11,
   parameter bit         ERASE_INIT = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sck,
   input  logic                     cs_n,
   input  logic                     si,
   input  logic                     wr_allow,
   output logic                     so,
   output logic                     so_oe,
   output logic [2:0]               blk_cfg,
   output logic [ADDR_W-COL_W-1:0]  tgt_page
);
   localparam int PG_W = ADDR_W - COL_W;

   if (ADDR_W < 9 || ADDR_W > 24 || COL_W < 1 || COL_W >= ADDR_W) begin : g_chk_geom
      $error("ADDR_W must lie in 9..24 and exceed COL_W");
   end

   logic sck_q, cs_q;
   logic rise, fall, cs_fall, cs_rise;
   logic byte_done;
   logic [7:0] rx_byte;
   logic [2:0] bit_idx;
   smc_st_e st;
   logic is_wr, wen, wpben, start;
   logic [1:0] bp, acnt, dcnt;
   logic [2:0] sr_val, ocnt;
   logic [ADDR_W-1:0] addr;
   logic [PG_W-1:0] cpage;
   logic [6:0] tx_sh;
   logic [7:0] src_byte, status, mem_rd, buf_rd;
   logic busy, t_done, t_copy, buf_mask, buf_any, out_st;
   logic [COL_W-1:0] t_idx;

   assign rise    = !cs_n && sck && !sck_q;
   assign fall    = !cs_n && !sck && sck_q;
   assign cs_fall = !cs_n && cs_q;
   assign cs_rise = cs_n && !cs_q;
   assign out_st  = (st == S_RD) || (st == S_SROUT) || (st == S_ID);
   assign status  = {wpben, 3'b000, bp, wen, busy};

   smc_rx u_rx (
      .clk(clk), .rst_n(rst_n), .clr(cs_n), .rise(rise), .si(si),
      .byte_done(byte_done), .byte_val(rx_byte), .bit_idx(bit_idx));

   smc_pgbuf #(.COL_W(COL_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(cs_fall && !busy),
      .ld(byte_done && st == S_WDATA), .ld_col(addr[COL_W-1:0]), .ld_data(rx_byte),
      .rd_col(t_idx), .rd_data(buf_rd), .rd_mask(buf_mask), .any(buf_any));

   smc_wtimer #(.WR_CYCLES(WR_CYCLES), .COL_W(COL_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(start),
      .busy(busy), .done(t_done), .copy(t_copy), .idx(t_idx));

   smc_mem #(.ADDR_W(ADDR_W), .ERASE_INIT(ERASE_INIT)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(t_copy && buf_mask),
      .waddr({cpage, t_idx}), .wdata(buf_rd), .raddr(addr), .rdata(mem_rd));

   always_comb begin
      case (st)
         S_RD:    src_byte = mem_rd;
         S_SROUT: src_byte = status;
         default: src_byte = SIG;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;  cs_q <= 1'b1;
         st <= S_OPC;    is_wr <= 1'b0;
         wen <= 1'b0;    wpben <= 1'b0;  bp <= '0;
         start <= 1'b0;  acnt <= '0;     dcnt <= '0;
         sr_val <= '0;   ocnt <= '0;     addr <= '0;
         cpage <= '0;    tx_sh <= '0;    so <= 1'b0;  so_oe <= 1'b0;
      end else begin
         sck_q <= sck;
         cs_q  <= cs_n;
         start <= 1'b0;
         if (t_done) wen <= 1'b0;
         if (cs_rise) begin
            if (st == S_WDATA && bit_idx == 3'd0 && buf_any && wen && wr_allow) begin
               start <= 1'b1;
               cpage <= addr[ADDR_W-1:COL_W];
            end
            if (st == S_SRDONE && wen) begin
               {wpben, bp} <= sr_val;
               wen <= 1'b0;
            end
         end
         if (cs_n) begin
            st <= S_OPC;  acnt <= '0;  dcnt <= '0;  ocnt <= '0;
         end else if (byte_done) begin
            case (st)
               S_OPC: begin
                  if (busy && rx_byte != OP_SR_RD) st <= S_SKIP;
                  else case (rx_byte)
                     OP_WEN:   begin wen <= 1'b1; st <= S_SKIP; end
                     OP_WDIS:  begin wen <= 1'b0; st <= S_SKIP; end
                     OP_SR_RD: st <= S_SROUT;
                     OP_SR_WR: st <= S_SRIN;
                     OP_RD:    begin is_wr <= 1'b0; st <= S_ADDR; end
                     OP_PG_WR: begin is_wr <= 1'b1; st <= S_ADDR; end
                     OP_SIG:   st <= S_DUMMY;
                     default:  st <= S_SKIP;
                  endcase
               end
               S_ADDR: begin
                  addr <= {addr[ADDR_W-9:0], rx_byte};
                  acnt <= acnt + 2'd1;
                  if (acnt == 2'd2) st <= is_wr ? S_WDATA : S_RD;
               end
               S_WDATA: addr <= {addr[ADDR_W-1:COL_W], addr[COL_W-1:0] + 1'b1};
               S_SRIN: begin
                  sr_val <= {rx_byte[7], rx_byte[3:2]};
                  st     <= S_SRDONE;
               end
               S_DUMMY: begin
                  dcnt <= dcnt + 2'd1;
                  if (dcnt == 2'd2) st <= S_ID;
               end
               default: ;
            endcase
         end else if (rise && st == S_SRDONE) begin
            st <= S_SKIP;
         end
         if (fall && out_st) begin
            ocnt <= ocnt + 3'd1;
            if (ocnt == 3'd0) begin
               so    <= src_byte[7];
               tx_sh <= src_byte[6:0];
            end else begin
               so    <= tx_sh[6];
               tx_sh <= {tx_sh[5:0], 1'b0};
            end
            if (ocnt == 3'd7 && st == S_RD) addr <= addr + 1'b1;
         end
         if (cs_n || !out_st) so_oe <= 1'b0;
         else if (fall)       so_oe <= 1'b1;
      end
   end

   assign blk_cfg  = {wpben, bp};
   assign tgt_page = addr[ADDR_W-1:COL_W];

   // R1: output stays disabled once the device is deselected
   a_r1_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n)) |-> !so_oe);
   // R4: the stored protection bits change only with write-enable set
   a_r4_cfg_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(blk_cfg) |-> $past(wen));
   // R7: a commit requires write-enable and the external permit
   a_r7_commit_gate: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> ($past(wen) && $past(wr_allow)));
   // R9: a non-status opcode during busy is skipped
   a_r9_busy_skip: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && byte_done && st == S_OPC && rx_byte != OP_SR_RD) |=> (st == S_SKIP || cs_n));
   // R11: a skipped selection never enables the output
   a_r11_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_SKIP && $past(st == S_SKIP)) |-> !so_oe);
endmodule

// File: tb/tb_smc_engine.sv
module tb_smc_engine;
   localparam int WRC = 600;

   typedef struct packed { logic [7:0] v; logic [7:0] rq; } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wr_allow = 1'b1;
   logic so, so_oe;
   logic [2:0] blk_cfg;
   logic [2:0] tgt_page;

   smc_engine #(.ADDR_W(11), .COL_W(8), .WR_CYCLES(WRC)) dut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .wr_allow(wr_allow),
      .so(so), .so_oe(so_oe), .blk_cfg(blk_cfg), .tgt_page(tgt_page));

   always #10 clk = ~clk;

   int n_cmp = 0, n_bad = 0, cyc = 0, oe_cnt = 0;
   bit m3 = 1'b0;
   exp_t exp_q[$];
   logic [7:0] act_q[$];
   exp_t me;
   logic [7:0] ma;

   always @(negedge clk) if (so_oe) oe_cnt++;

   // scoreboard monitor
   always @(negedge clk) begin
      if (exp_q.size() > 0 && act_q.size() > 0) begin
         me = exp_q.pop_front();
         ma = act_q.pop_front();
         n_cmp++;
         if (ma !== me.v) begin
            n_bad++;
            $display("FAIL R%0d: got %02h expected %02h", me.rq, ma, me.v);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
         $finish;
      end
   end

   task automatic hclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input int rq);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d: got %02h expected %02h", rq, act, exp);
      end
   endtask

   task automatic expb(input logic [7:0] v, input int rq);
      exp_q.push_back({v, 8'(rq)});
   endtask

   task automatic cs_lo();
      sck = m3; hclk(2); cs_n = 1'b0; hclk(2);
   endtask

   task automatic cs_hi();
      if (!m3) begin sck = 1'b0; hclk(2); end
      cs_n = 1'b1; hclk(4);
   endtask

   task automatic xbyte(input logic [7:0] tx, input bit cap);
      logic [7:0] rx;
      for (int b = 7; b >= 0; b--) begin
         sck = 1'b0; si = tx[b]; hclk(2);
         rx[b] = so;
         sck = 1'b1; hclk(2);
      end
      if (cap) act_q.push_back(rx);
   endtask

   task automatic xbits(input int n);
      for (int b = 0; b < n; b++) begin
         sck = 1'b0; si = 1'b1; hclk(2); sck = 1'b1; hclk(2);
      end
   endtask

   task automatic op1(input logic [7:0] op);
      cs_lo(); xbyte(op, 0); cs_hi();
   endtask

   task automatic rdsr(input logic [7:0] exp, input int rq);
      cs_lo(); xbyte(8'h05, 0); expb(exp, rq); xbyte(8'h00, 1); cs_hi();
   endtask

   task automatic open(input logic [7:0] op, input logic [23:0] a);
      cs_lo(); xbyte(op, 0);
      xbyte(a[23:16], 0); xbyte(a[15:8], 0); xbyte(a[7:0], 0);
   endtask

   task automatic wr1(input logic [23:0] a, input logic [7:0] d);
      open(8'h02, a); xbyte(d, 0); cs_hi();
   endtask

   task automatic rdexp(input logic [23:0] a, input logic [7:0] e0, input int rq);
      open(8'h03, a); expb(e0, rq); xbyte(8'h00, 1); cs_hi();
   endtask

   initial begin
      hclk(4);
      rst_n = 1'b1;
      hclk(4);
      // R1 / R4: reset state
      chk({7'd0, so_oe}, 8'h00, 1);
      chk({5'd0, blk_cfg}, 8'h00, 4);

      // R2: status read repeats its byte
      cs_lo(); xbyte(8'h05, 0);
      expb(8'h00, 2); xbyte(8'h00, 1);
      expb(8'h00, 2); xbyte(8'h00, 1);
      cs_hi();

      // R3: enable then disable
      op1(8'h06); rdsr(8'h02, 3);
      op1(8'h04); rdsr(8'h00, 3);

      // R7: write without enable is ignored
      wr1(24'h000010, 8'hA5);
      rdsr(8'h00, 7);
      rdexp(24'h000010, 8'hFF, 7);

      // R12 / R8 / R6: short page write in page 1
      op1(8'h06);
      open(8'h02, 24'h000130);
      xbyte(8'h11, 0); xbyte(8'h22, 0); xbyte(8'h33, 0);
      chk({5'd0, tgt_page}, 8'h01, 12); // R12
      cs_hi();
      rdsr(8'h03, 8); // R8 busy with enable shown
      hclk(WRC + 50);
      rdsr(8'h00, 8); // R8 enable cleared at end
      open(8'h03, 24'h00012F);
      expb(8'hFF, 6); xbyte(8'h00, 1);
      expb(8'h11, 5); xbyte(8'h00, 1);
      expb(8'h22, 5); xbyte(8'h00, 1);
      expb(8'h33, 5); xbyte(8'h00, 1);
      expb(8'hFF, 6); xbyte(8'h00, 1);
      cs_hi();

      // R6: 258 bytes from column FE wrap and overwrite
      op1(8'h06);
      open(8'h02, 24'h0002FE);
      for (int k = 0; k < 258; k++) xbyte(8'((k * 3) & 255), 0);
      cs_hi();
      hclk(WRC + 50);
      open(8'h03, 24'h000200);
      expb(8'h06, 6); xbyte(8'h00, 1);
      expb(8'h09, 6); xbyte(8'h00, 1);
      cs_hi();
      open(8'h03, 24'h0002FE);
      expb(8'h00, 6); xbyte(8'h00, 1);
      expb(8'h03, 6); xbyte(8'h00, 1);
      expb(8'hFF, 6); xbyte(8'h00, 1);
      cs_hi();

      // R5: full-array rollover, high address bits ignored
      op1(8'h06); wr1(24'hAB07FF, 8'hC3); hclk(WRC + 50);
      op1(8'h06); wr1(24'h000000, 8'h3C); hclk(WRC + 50);
      open(8'h03, 24'h0007FE);
      expb(8'hFF, 5); xbyte(8'h00, 1);
      expb(8'hC3, 5); xbyte(8'h00, 1);
      expb(8'h3C, 5); xbyte(8'h00, 1);
      expb(8'hFF, 5); xbyte(8'h00, 1);
      cs_hi();

      // R7: mid-byte deselect cancels
      op1(8'h06);
      open(8'h02, 24'h000040); xbyte(8'h77, 0); xbits(4); cs_hi();
      rdsr(8'h02, 7);
      rdexp(24'h000040, 8'hFF, 7);
      // R7: permit withheld
      wr_allow = 1'b0;
      wr1(24'h000050, 8'h99);
      wr_allow = 1'b1;
      rdsr(8'h02, 7);
      rdexp(24'h000050, 8'hFF, 7);
      op1(8'h04);

      // R9: busy window ignores everything but status read
      op1(8'h06); wr1(24'h000180, 8'h5E);
      rdsr(8'h03, 9);
      begin
         int snap;
         snap = oe_cnt;
         open(8'h03, 24'h000130); xbyte(8'h00, 0); cs_hi();
         cs_lo(); xbyte(8'hAB, 0); xbyte(0, 0); xbyte(0, 0); xbyte(0, 0); xbyte(0, 0); cs_hi();
         wr1(24'h000060, 8'h12);
         chk(8'(oe_cnt - snap), 8'h00, 9);
      end
      hclk(WRC + 50);
      rdsr(8'h00, 9);
      rdexp(24'h000060, 8'hFF, 9);
      rdexp(24'h000180, 8'h5E, 9);

      // R4: status write
      op1(8'h06);
      cs_lo(); xbyte(8'h01, 0); xbyte(8'h8C, 0); cs_hi();
      rdsr(8'h8C, 4);
      chk({5'd0, blk_cfg}, 8'h07, 4);
      cs_lo(); xbyte(8'h01, 0); xbyte(8'h00, 0); cs_hi();
      rdsr(8'h8C, 4);
      op1(8'h06);
      cs_lo(); xbyte(8'h01, 0); xbyte(8'h74, 0); cs_hi();
      rdsr(8'h04, 4);
      chk({5'd0, blk_cfg}, 8'h01, 4);
      op1(8'h06);
      cs_lo(); xbyte(8'h01, 0); xbyte(8'h00, 0); xbyte(8'h8C, 0); cs_hi();
      rdsr(8'h06, 4); // two data bytes: not applied, enable kept
      cs_lo(); xbyte(8'h01, 0); xbyte(8'h00, 0); cs_hi();
      rdsr(8'h00, 4);

      // R10: signature after three dummy bytes, repeated
      cs_lo(); xbyte(8'hAB, 0); xbyte(0, 0); xbyte(0, 0); xbyte(0, 0);
      expb(8'h11, 10); xbyte(8'h00, 1);
      expb(8'h11, 10); xbyte(8'h00, 1);
      cs_hi();

      // R11: unknown opcode silences the rest of the selection
      begin
         int snap;
         snap = oe_cnt;
         cs_lo(); xbyte(8'h5A, 0); xbyte(8'h06, 0); xbyte(8'h05, 0); cs_hi();
         chk(8'(oe_cnt - snap), 8'h00, 11);
      end
      rdsr(8'h00, 11);

      // R1: clock mode 3
      m3 = 1'b1;
      op1(8'h06);
      rdsr(8'h02, 1);
      rdexp(24'h000131, 8'h22, 1);
      op1(8'h04);
      m3 = 1'b0;
      sck = 1'b0;

      hclk(20);
      chk(8'(exp_q.size()), 8'(act_q.size()), 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule